// File: doc/BRIEF.md
# Scatter-Gather Host Write DMA Engine

This engine moves a local word stream into host memory as PCIe memory-write TLPs. Before a run, software writes descriptors into an internal queue through a write port. Each descriptor holds a 64-bit physical byte address and a byte length. A `start` pulse begins the run. The engine takes the descriptors in the order they were written. It cuts each region into requests so that no request crosses a 4 KB page or goes past the maximum payload size. For each request it builds the header and then forwards one stream word for each payload DW. The stream words are already placed in the byte lanes of the host address.

The header is chosen per request. A target below 4 GB gets a three-DW header with a 32-bit address. A target at or above 4 GB gets a four-DW header with a 64-bit address. When the queue runs dry, the engine can send a flush read if `flush_en` was set at start. This read has a length of one DW, both byte enables at zero, and targets the DW holding the last byte written. The engine waits for its completion and discards the contents. It then pulses `irq` and sets `done`.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for `start`.
- `ST_FETCH`: pops a descriptor. A zero-length descriptor goes back to `ST_FETCH`. Otherwise it moves to `ST_PLAN`. An empty queue moves to `ST_FLUSH` if a flush is due, else to `ST_FINISH`.
- `ST_PLAN`: latches the next request and moves to `ST_HDR`.
- `ST_HDR`: after the last header DW, moves to `ST_DATA`.
- `ST_DATA`: after the last payload DW, moves to `ST_PLAN` if bytes remain, else to `ST_FETCH`.
- `ST_FLUSH`: after the last read-header DW, moves to `ST_WAIT_CPL`.
- `ST_WAIT_CPL`: on `cpl_valid`, moves to `ST_FINISH`.
- `ST_FINISH`: pulses `irq`, sets `done` and returns to `ST_IDLE`.

Top module: `sg_dma_writer`

## Requirements
- R1: Descriptors are used in the order they were written, and each one yields its requests in rising address order. A descriptor of length zero is dropped and produces no TLP.
- R2: A request whose address has bits 63:32 all zero uses a 3-DW write header. Word 0 is 0x40000000 with the DW count in bits 9:0. Word 2 is the address with bits 1:0 cleared.
- R3: A request whose upper address half is nonzero uses a 4-DW write header. Word 0 is 0x60000000 with the DW count. Word 2 is address bits 63:32 and word 3 is the low half with bits 1:0 cleared. No 4-DW header ever carries an all-zero upper half.
- R4: No request spans a 4096-byte address boundary. A region that crosses one is split there.
- R5: The DW count of a request, which includes the lead-in offset addr[1:0], never exceeds MPS_BYTES/4. A longer region is split into several requests.
- R6: Header word 1 holds REQ_ID in bits 31:16, tag zero in bits 15:8, the last byte enable in bits 7:4 and the first byte enable in bits 3:0. The first enable has lanes addr[1:0] through 3 set. The last enable has lanes 0 through the end offset set. A one-DW request merges both masks into the first enable and sets the last enable to 0000.
- R7: Payload DWs are the stream words in arrival order, one word per DW. `tlp_last` marks the final DW of each TLP.
- R8: While `tlp_valid` is high and `tlp_ready` is low, `tlp_valid`, `tlp_data` and `tlp_last` hold their values.
- R9: If `flush_en` was high at start and at least one byte was written, a read TLP follows the writes. It has length 1, both byte enables zero, and targets the DW holding the last byte written. Word 0 is 0x00000001 with a 3-DW header or 0x20000001 with a 4-DW header. The engine does not finish until `cpl_valid` arrives.
- R10: At the end of a run, `irq` pulses high for one cycle. `done` rises in the same cycle and stays high until the next accepted `start`.
- R11: After reset, `tlp_valid`, `irq`, `done` and `s_ready` are low and `dsc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsc_valid | input | 1 | Descriptor write strobe |
| dsc_ready | output | 1 | Descriptor queue has room |
| dsc_addr | input | 64 | Descriptor host byte address |
| dsc_len | input | LEN_W | Descriptor byte length |
| start | input | 1 | Begin a run (sampled in idle) |
| flush_en | input | 1 | Request a flush read for this run |
| s_data | input | 32 | Stream payload word, host-lane aligned |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted |
| tlp_data | output | 32 | TLP word |
| tlp_valid | output | 1 | TLP word valid |
| tlp_last | output | 1 | Final word of the TLP |
| tlp_ready | input | 1 | TLP sink ready |
| cpl_valid | input | 1 | Completion arrived (contents discarded) |
| cpl_data | input | 32 | Completion word (ignored) |
| irq | output | 1 | One-cycle end-of-run interrupt request |
| done | output | 1 | Run finished |

## Verification
The splitter is tried on several kinds of region:
- Aligned short regions below and above 4 GB, including addresses exactly at 0xFFFFFFFC and at 0x100000000. These separate the two header formats.
- Unaligned regions that fit in one DW or span a few. These separate the byte-enable rules.
- A region crossing a page and regions longer than the payload limit, with aligned and unaligned starts. These separate page splitting from size splitting.

A list with a zero-length entry between two others checks ordering and skipping. Runs with random stalls on both sides of the engine check that words hold steady. Flush runs cover both header widths and an empty list, so the case where no flush is sent is told apart from the case where one is.

// File: rtl/sg_dma_pkg.sv
`timescale 1ns/1ps
package sg_dma_pkg;
    localparam int ADDR_W     = 64;
    localparam int WORD_W     = 32;
    localparam int PAGE_BYTES = 4096;
    localparam int CHUNK_W    = 13;   // holds 0..4096
    localparam int NDW_W      = 11;   // holds 0..1024

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_PLAN,
        ST_HDR,
        ST_DATA,
        ST_FLUSH,
        ST_WAIT_CPL,
        ST_FINISH
    } dma_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [CHUNK_W-1:0] nbytes;
        logic [NDW_W-1:0]   ndw;
        logic [3:0]         first_be;
        logic [3:0]         last_be;
    } req_t;
endpackage

// File: rtl/sg_desc_fifo.sv
`timescale 1ns/1ps
module sg_desc_fifo #(
    parameter int WIDTH = 80,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    output logic             full,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [AW:0]      cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == (AW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/sg_req_split.sv
`timescale 1ns/1ps
module sg_req_split
    import sg_dma_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int MPS_BYTES = 128
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  rem,
    output req_t              req
);
    logic [31:0] rem32, page_room, mps_room, lim, chunk, ndw32;
    logic [1:0]  off, end_off;
    logic [3:0]  head_mask, tail_mask;
    logic        unused_split;

    always_comb begin
        off       = addr[1:0];
        rem32     = 32'(rem);
        page_room = 32'(PAGE_BYTES) - {20'd0, addr[11:0]};
        mps_room  = 32'(MPS_BYTES) - {30'd0, off};
        lim       = (page_room < mps_room) ? page_room : mps_room;
        chunk     = (rem32 < lim) ? rem32 : lim;
        ndw32     = ({30'd0, off} + chunk + 32'd3) >> 2;
        end_off   = off + chunk[1:0] - 2'd1;
        head_mask = 4'b1111 << off;
        tail_mask = 4'b1111 >> (2'd3 - end_off);

        req.addr   = addr;
        req.nbytes = chunk[CHUNK_W-1:0];
        req.ndw    = ndw32[NDW_W-1:0];
        if (ndw32 == 32'd1) begin
            req.first_be = head_mask & tail_mask;
            req.last_be  = 4'b0000;
        end else begin
            req.first_be = head_mask;
            req.last_be  = tail_mask;
        end
    end

    assign unused_split = ^{chunk[31:CHUNK_W], ndw32[31:NDW_W]};
endmodule

// File: rtl/sg_hdr_build.sv
`timescale 1ns/1ps
module sg_hdr_build
    import sg_dma_pkg::*;
#(
    parameter logic [15:0] REQ_ID = 16'h0100
) (
    input  logic              is_read,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NDW_W-1:0]  ndw,
    input  logic [3:0]        first_be,
    input  logic [3:0]        last_be,
    input  logic [1:0]        idx,
    output logic [WORD_W-1:0] word,
    output logic [2:0]        hlen
);
    logic              wide;
    logic [2:0]        fmt;
    logic [WORD_W-1:0] w0, w1, lo;
    logic              unused_hdr;

    always_comb begin
        wide = |addr[63:32];
        fmt  = {1'b0, ~is_read, wide};
        w0   = {fmt, 5'b00000, 14'd0, ndw[9:0]};
        w1   = {REQ_ID, 8'h00, last_be, first_be};
        lo   = {addr[31:2], 2'b00};
        hlen = wide ? 3'd4 : 3'd3;
        unique case (idx)
            2'd0:    word = w0;
            2'd1:    word = w1;
            2'd2:    word = wide ? addr[63:32] : lo;
            default: word = lo;
        endcase
    end

    assign unused_hdr = ndw[NDW_W-1];
endmodule

// File: rtl/sg_dma_writer.sv
`timescale 1ns/1ps
module sg_dma_writer
    import sg_dma_pkg::*;
#(
    parameter int          LEN_W      = 16,
    parameter int          DESC_DEPTH = 8,
    parameter int          MPS_BYTES  = 128,
    parameter logic [15:0] REQ_ID     = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dsc_valid,
    output logic              dsc_ready,
    input  logic [63:0]       dsc_addr,
    input  logic [LEN_W-1:0]  dsc_len,
    input  logic              start,
    input  logic              flush_en,
    input  logic [31:0]       s_data,
    input  logic              s_valid,
    output logic              s_ready,
    output logic [31:0]       tlp_data,
    output logic              tlp_valid,
    output logic              tlp_last,
    input  logic              tlp_ready,
    input  logic              cpl_valid,
    input  logic [31:0]       cpl_data,
    output logic              irq,
    output logic              done
);
    localparam int DESC_W = ADDR_W + LEN_W;

    dma_state_e state_q, state_d;

    logic              fifo_full, fifo_empty, fifo_pop;
    logic [DESC_W-1:0] fifo_head;
    logic [ADDR_W-1:0] head_addr;
    logic [LEN_W-1:0]  head_len;

    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  cur_rem;
    req_t              split_req, req_q;

    logic [NDW_W-1:0]  beat_idx;
    logic              slot_free, beat_fire, hdr_end, data_end;
    logic              flush_q, wrote_any;
    logic [ADDR_W-1:0] last_dw_addr;

    logic              hb_read;
    logic [ADDR_W-1:0] hb_addr;
    logic [NDW_W-1:0]  hb_ndw;
    logic [3:0]        hb_fbe, hb_lbe;
    logic [WORD_W-1:0] hb_word;
    logic [2:0]        hb_hlen;

    logic [31:0]       data_q;
    logic              valid_q, last_q, irq_q, done_q;
    logic              unused_cpl;

    // ---------------- sub-blocks ----------------
    sg_desc_fifo #(.WIDTH(DESC_W), .DEPTH(DESC_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (dsc_valid),
        .wdata ({dsc_addr, dsc_len}),
        .full  (fifo_full),
        .pop   (fifo_pop),
        .rdata (fifo_head),
        .empty (fifo_empty)
    );

    assign head_addr = fifo_head[DESC_W-1:LEN_W];
    assign head_len  = fifo_head[LEN_W-1:0];

    sg_req_split #(.LEN_W(LEN_W), .MPS_BYTES(MPS_BYTES)) u_split (
        .addr (cur_addr),
        .rem  (cur_rem),
        .req  (split_req)
    );

    assign hb_read = (state_q == ST_FLUSH);
    assign hb_addr = hb_read ? last_dw_addr : req_q.addr;
    assign hb_ndw  = hb_read ? NDW_W'(1) : req_q.ndw;
    assign hb_fbe  = hb_read ? 4'b0000 : req_q.first_be;
    assign hb_lbe  = hb_read ? 4'b0000 : req_q.last_be;

    sg_hdr_build #(.REQ_ID(REQ_ID)) u_hdr (
        .is_read  (hb_read),
        .addr     (hb_addr),
        .ndw      (hb_ndw),
        .first_be (hb_fbe),
        .last_be  (hb_lbe),
        .idx      (beat_idx[1:0]),
        .word     (hb_word),
        .hlen     (hb_hlen)
    );

    // ---------------- handshake helpers ----------------
    assign slot_free = !valid_q || tlp_ready;
    assign beat_fire = slot_free && ((state_q == ST_HDR) || (state_q == ST_FLUSH) ||
                                     ((state_q == ST_DATA) && s_valid));
    assign hdr_end   = beat_idx == NDW_W'(hb_hlen - 3'd1);
    assign data_end  = beat_idx == (req_q.ndw - 1'b1);
    assign fifo_pop  = (state_q == ST_FETCH) && !fifo_empty;

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_FETCH;
            ST_FETCH: begin
                if (fifo_empty) begin
                    state_d = (flush_q && wrote_any) ? ST_FLUSH : ST_FINISH;
                end else if (head_len != '0) begin
                    state_d = ST_PLAN;
                end
            end
            ST_PLAN:     state_d = ST_HDR;
            ST_HDR:      if (beat_fire && hdr_end) state_d = ST_DATA;
            ST_DATA: begin
                if (beat_fire && data_end) begin
                    state_d = (cur_rem == '0) ? ST_FETCH : ST_PLAN;
                end
            end
            ST_FLUSH:    if (beat_fire && hdr_end) state_d = ST_WAIT_CPL;
            ST_WAIT_CPL: if (cpl_valid) state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- datapath and outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr     <= '0;
            cur_rem      <= '0;
            req_q        <= '0;
            beat_idx     <= '0;
            flush_q      <= 1'b0;
            wrote_any    <= 1'b0;
            last_dw_addr <= '0;
            data_q       <= '0;
            valid_q      <= 1'b0;
            last_q       <= 1'b0;
            irq_q        <= 1'b0;
            done_q       <= 1'b0;
        end else begin
            irq_q <= 1'b0;

            if (state_d != state_q) begin
                beat_idx <= '0;
            end else if (beat_fire) begin
                beat_idx <= beat_idx + 1'b1;
            end

            if (beat_fire) begin
                valid_q <= 1'b1;
                if (state_q == ST_DATA) begin
                    data_q <= s_data;
                    last_q <= data_end;
                end else begin
                    data_q <= hb_word;
                    last_q <= (state_q == ST_FLUSH) && hdr_end;
                end
            end else if (tlp_ready) begin
                valid_q <= 1'b0;
            end

            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        flush_q   <= flush_en;
                        wrote_any <= 1'b0;
                        done_q    <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    if (!fifo_empty) begin
                        cur_addr <= head_addr;
                        cur_rem  <= head_len;
                    end
                end
                ST_PLAN: begin
                    req_q        <= split_req;
                    cur_addr     <= cur_addr + 64'(split_req.nbytes);
                    cur_rem      <= cur_rem - LEN_W'(split_req.nbytes);
                    last_dw_addr <= (cur_addr + 64'(split_req.nbytes) - 64'd1) & ~64'd3;
                    wrote_any    <= 1'b1;
                end
                ST_FINISH: begin
                    irq_q  <= 1'b1;
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign dsc_ready  = !fifo_full;
    assign s_ready    = (state_q == ST_DATA) && slot_free;
    assign tlp_data   = data_q;
    assign tlp_valid  = valid_q;
    assign tlp_last   = last_q;
    assign irq        = irq_q;
    assign done       = done_q;
    assign unused_cpl = ^cpl_data;
endmodule

// File: rtl/sg_dma_writer_chk.sv
`timescale 1ns/1ps
module sg_dma_writer_chk #(
    parameter int MPS_BYTES = 128
) (
    input logic        clk,
    input logic        rst_n,
    input logic        tlp_valid,
    input logic        tlp_ready,
    input logic        tlp_last,
    input logic [31:0] tlp_data,
    input logic        irq,
    input logic        done
);
    logic [1:0] pos;
    logic       first_wide, first_rd;
    logic       hs;

    assign hs = tlp_valid && tlp_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos        <= '0;
            first_wide <= 1'b0;
            first_rd   <= 1'b0;
        end else if (hs) begin
            if (tlp_last) begin
                pos <= '0;
            end else if (pos != 2'd3) begin
                pos <= pos + 1'b1;
            end
            if (pos == 2'd0) begin
                first_wide <= tlp_data[29];
                first_rd   <= !tlp_data[30];
            end
        end
    end

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (tlp_valid && !tlp_ready) |=> (tlp_valid && $stable(tlp_data) && $stable(tlp_last)));

    a_r5_len_within_mps: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && pos == 2'd0 && tlp_data[30]) |->
        (tlp_data[9:0] != 10'd0 && tlp_data[9:0] <= 10'(MPS_BYTES / 4)));

    a_r3_upper_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && pos == 2'd2 && first_wide) |-> (tlp_data != 32'd0));

    a_r9_flush_be_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && pos == 2'd1 && first_rd) |-> (tlp_data[7:0] == 8'h00));

    a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r10_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
endmodule

bind sg_dma_writer sg_dma_writer_chk #(.MPS_BYTES(MPS_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tlp_valid (tlp_valid),
    .tlp_ready (tlp_ready),
    .tlp_last  (tlp_last),
    .tlp_data  (tlp_data),
    .irq       (irq),
    .done      (done)
);

// File: tb/sg_dma_writer_tb_top.sv
`timescale 1ns/1ps
module sg_dma_writer_tb_top;
    localparam int          LEN_W  = 16;
    localparam int          MPS    = 128;
    localparam logic [15:0] RID    = 16'h0100;

    typedef struct packed {
        logic        rd_end;
        logic        last;
        logic [31:0] data;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dsc_valid = 1'b0;
    logic              dsc_ready;
    logic [63:0]       dsc_addr = '0;
    logic [LEN_W-1:0]  dsc_len = '0;
    logic              start = 1'b0;
    logic              flush_en = 1'b0;
    logic [31:0]       s_data = '0;
    logic              s_valid = 1'b0;
    logic              s_ready;
    logic [31:0]       tlp_data;
    logic              tlp_valid, tlp_last;
    logic              tlp_ready = 1'b0;
    logic              cpl_valid = 1'b0;
    logic [31:0]       cpl_data = 32'hDEAD_BEEF;
    logic              irq, done;

    int checks = 0;
    int failures = 0;
    exp_t exp_q[$];
    string cur_tag = "R11";
    bit    bp_on = 1'b0;
    int    in_ctr = 0;
    int    exp_w = 0;
    int    irq_count = 0;
    int    tlp_count = 0;
    int    cpl_cnt = 0;
    bit    first_seen = 1'b0;
    logic [31:0] first_word = '0;
    logic [15:0] lfsr = 16'hACE1;
    bit    wrote_model = 1'b0;
    logic [63:0] model_last = '0;

    always #4 clk = ~clk;

    sg_dma_writer #(.LEN_W(LEN_W), .DESC_DEPTH(8), .MPS_BYTES(MPS), .REQ_ID(RID)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .dsc_valid(dsc_valid), .dsc_ready(dsc_ready), .dsc_addr(dsc_addr), .dsc_len(dsc_len),
        .start(start), .flush_en(flush_en),
        .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .tlp_data(tlp_data), .tlp_valid(tlp_valid), .tlp_last(tlp_last), .tlp_ready(tlp_ready),
        .cpl_valid(cpl_valid), .cpl_data(cpl_data),
        .irq(irq), .done(done)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] dw0(input bit rd, input bit wide, input int unsigned n);
        return {1'b0, ~rd, wide, 5'b0, 14'd0, 10'(n)};
    endfunction

    task automatic push_hdr(input bit rd, input logic [63:0] a, input int unsigned n,
                            input logic [3:0] fb, input logic [3:0] lb);
        bit wide;
        wide = (a[63:32] != 32'd0);
        exp_q.push_back('{1'b0, 1'b0, dw0(rd, wide, n)});
        exp_q.push_back('{1'b0, 1'b0, {RID, 8'h00, lb, fb}});
        if (wide) exp_q.push_back('{1'b0, 1'b0, a[63:32]});
        exp_q.push_back('{rd, rd, {a[31:2], 2'b00}});
    endtask

    // Expected TLPs for one descriptor, built from the splitting and enable rules
    task automatic model_desc(input logic [63:0] a, input int unsigned len);
        logic [63:0] p;
        int unsigned left;
        p = a;
        left = len;
        while (left > 0) begin
            int unsigned off, room, mr, lim, ch, nd, eo;
            logic [3:0] fb, lb;
            off  = p[1:0];
            room = 4096 - p[11:0];
            mr   = MPS - off;
            lim  = (room < mr) ? room : mr;
            ch   = (left < lim) ? left : lim;
            nd   = (off + ch + 3) / 4;
            eo   = (off + ch - 1) % 4;
            fb   = 4'hF << off;
            lb   = 4'hF >> (3 - eo);
            if (nd == 1) begin
                fb = fb & lb;
                lb = 4'h0;
            end
            push_hdr(1'b0, p, nd, fb, lb);
            for (int k = 0; k < int'(nd); k++) begin
                exp_q.push_back('{1'b0, (k == int'(nd) - 1), 32'hC0DE_0000 + 32'(exp_w)});
                exp_w++;
            end
            model_last  = (p + 64'(ch) - 64'd1) & ~64'd3;
            wrote_model = 1'b1;
            p    = p + 64'(ch);
            left = left - ch;
        end
    endtask

    task automatic push_desc(input logic [63:0] a, input int unsigned len);
        @(negedge clk);
        dsc_valid = 1'b1;
        dsc_addr  = a;
        dsc_len   = LEN_W'(len);
        @(negedge clk);
        dsc_valid = 1'b0;
        model_desc(a, len);
    endtask

    task automatic run_case(input string tag, input bit fl, input bit bp, input int exp_tlps);
        int t0, i0;
        t0 = tlp_count;
        i0 = irq_count;
        bp_on = bp;
        cur_tag = tag;
        first_seen = 1'b0;
        if (fl && wrote_model) push_hdr(1'b1, model_last, 1, 4'h0, 4'h0);
        @(negedge clk);
        start = 1'b1;
        flush_en = fl;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        while (!done) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, {tag, " all expected beats seen"}, 64'(exp_q.size()), 64'd0);
        check(tlp_count - t0 == exp_tlps, {tag, " TLP count"}, 64'(tlp_count - t0), 64'(exp_tlps));
        check(irq_count - i0 == 1, "R10 one irq per run", 64'(irq_count - i0), 64'd1);
        check(done && !irq, "R10 done held, irq dropped", {62'd0, done, irq}, 64'd2);
        wrote_model = 1'b0;
        exp_q.delete();
    endtask

    // Driver and monitor: inputs change at the falling edge, sampling 1 ns before the rising edge
    initial begin
        forever begin
            @(negedge clk);
            lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tlp_ready = bp_on ? (lfsr[0] | lfsr[3]) : 1'b1;
            s_valid   = bp_on ? (lfsr[1] | lfsr[5]) : 1'b1;
            s_data    = 32'hC0DE_0000 + 32'(in_ctr);
            cpl_valid = (cpl_cnt == 1);
            if (cpl_cnt > 0) cpl_cnt--;
            #3;
            if (s_valid && s_ready) in_ctr++;
            if (irq) irq_count++;
            if (cpl_valid) check(!done, "R9 no finish before completion", {63'd0, done}, 64'd0);
            if (tlp_valid && tlp_ready) begin
                if (!first_seen) begin
                    first_seen = 1'b1;
                    first_word = tlp_data;
                end
                if (tlp_last) tlp_count++;
                if (exp_q.size() == 0) begin
                    check(1'b0, {cur_tag, "/R7 unexpected beat"}, {31'd0, tlp_last, tlp_data}, 64'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(tlp_data == e.data && tlp_last == e.last, {cur_tag, "/R7 beat"},
                          {31'd0, tlp_last, tlp_data}, {31'd0, e.last, e.data});
                    if (e.rd_end) cpl_cnt = 4;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        #3;
        check(!tlp_valid && !irq && !done && !s_ready && dsc_ready, "R11 reset state",
              {59'd0, tlp_valid, irq, done, s_ready, dsc_ready}, 64'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: aligned region under 4 GB
        push_desc(64'h0000_0000_1000_0000, 16);
        run_case("R2", 1'b0, 1'b0, 1);
        check(first_word == 32'h4000_0004, "R2 header word 0", 64'(first_word), 64'h4000_0004);

        // R3: above 4 GB, top of low space, exactly 4 GB
        push_desc(64'h0000_0001_2345_6780, 8);
        push_desc(64'h0000_0000_FFFF_FFFC, 4);
        push_desc(64'h0000_0001_0000_0000, 4);
        run_case("R3", 1'b0, 1'b0, 3);
        check(first_word == 32'h6000_0002, "R3 header word 0", 64'(first_word), 64'h6000_0002);

        // R6: unaligned multi-DW and single-DW requests
        push_desc(64'h2003, 6);
        push_desc(64'h3001, 2);
        run_case("R6", 1'b0, 1'b0, 2);

        // R4: page crossing
        push_desc(64'h0FF0, 64);
        run_case("R4", 1'b0, 1'b0, 2);

        // R5 and R8: payload size splits with stalls on both sides
        push_desc(64'h5000, 300);
        push_desc(64'h6002, 200);
        run_case("R5 R8", 1'b0, 1'b1, 5);

        // R1: ordering with a zero-length entry in the middle
        push_desc(64'h7000, 8);
        push_desc(64'h8000, 0);
        push_desc(64'h9000, 12);
        run_case("R1", 1'b0, 1'b1, 2);

        // R9: flush after writes, 3-DW then 4-DW read
        push_desc(64'hA000, 10);
        run_case("R9", 1'b1, 1'b0, 2);
        push_desc(64'h0000_0002_0000_0010, 4);
        run_case("R9 wide", 1'b1, 1'b1, 2);

        // R10: empty list with flush requested sends nothing and still finishes
        run_case("R10", 1'b1, 1'b0, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule